// File: doc/BRIEF.md
# SCSI Transfer Byte Counter

This block keeps the bookkeeping for one data movement between the SCSI bus and host memory. It holds a 24-bit count of bytes still to move and a 32-bit address of the next byte. The data path pulses a strobe once for every byte it has actually moved. Each accepted strobe lowers the count by one and raises the address by one in the same clock edge. A byte that was only requested, and not yet moved, never touches either register.

Two sticky status bits report progress. One says the count has come to rest at zero. The other says a strobe arrived at zero and the count wrapped to all ones. Each bit is cleared by writing a one to its clear position. Each bit is gated by its own enable bit, and the gated bits are ORed into one interrupt line. Host-side controls can load the count, load the address, or clear the count.

Top module: `xfer_byte_counter`

## Requirements
- R1: While rst_n is low, count_o and addr_o are zero, sts_done and sts_wrap are low, and irq is low.
- R2: An accepted byte_done strobe lowers count_o by one at the next clock edge. Without an update, count_o holds its value.
- R3: addr_o rises by one at the same edge at which an accepted strobe lowers the count. addr_o changes otherwise only on addr_load.
- R4: sts_done is set at the edge at which an update leaves the count at zero. The possible updates are a clear, a load of zero, or a decrement from one.
- R5: An accepted strobe while count_o is zero sets count_o to 0xFFFFFF and sets sts_wrap. The address still advances.
- R6: cnt_clear has priority over cnt_load. A byte_done strobe in a cycle with cnt_clear, cnt_load or addr_load asserted is dropped, so neither count_o nor addr_o moves for it. addr_load writes addr_val into addr_o.
- R7: sts_w1c bit 0 clears sts_done and bit 1 clears sts_wrap. A zero bit leaves its status unchanged. A status event in the same cycle wins over the clear.
- R8: irq is high exactly when (sts_done and irq_en bit 0) or (sts_wrap and irq_en bit 1). irq follows irq_en in the same cycle.
- R9: sts_done and sts_wrap stay set until they are cleared through sts_w1c or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_done | input | 1 | One byte has been moved safely |
| cnt_clear | input | 1 | Force the count to zero |
| cnt_load | input | 1 | Load the count from cnt_val |
| cnt_val | input | 24 | Count load value |
| addr_load | input | 1 | Load the address from addr_val |
| addr_val | input | 32 | Address load value |
| sts_w1c | input | 2 | Write-one-to-clear: bit 0 done, bit 1 wrap |
| irq_en | input | 2 | Interrupt enables: bit 0 done, bit 1 wrap |
| count_o | output | 24 | Remaining byte count |
| addr_o | output | 32 | Address of the next byte |
| sts_done | output | 1 | Count reached zero (sticky) |
| sts_wrap | output | 1 | Count wrapped below zero (sticky) |
| irq | output | 1 | Masked status interrupt |

## Verification
The assertions take for granted that every control input is a known 0 or 1 after reset. They also take for granted that inputs settle between edges. Any combination of strobe, clear, loads and clear-writes in one cycle is legal, and the properties are written for all of them. The stimulus therefore drives inputs only on the falling edge. It deliberately overlaps strobes with loads, clears and same-cycle status events. It keeps load values small so that zero crossings and wraps occur often.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  localparam int unsigned XBC_NSTAT = 2;
  localparam int unsigned ST_DONE   = 0;
  localparam int unsigned ST_WRAP   = 1;
endpackage

// File: rtl/xbc_count.sv
module xbc_count #(
  parameter int unsigned CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] cnt_q,
  output logic          zero_evt,
  output logic          wrap_evt
);
  logic [CW-1:0] cnt_d;
  logic          upd;

  always_comb begin
    cnt_d = cnt_q;
    upd   = 1'b0;
    if (clr) begin
      cnt_d = '0;
      upd   = 1'b1;
    end else if (load) begin
      cnt_d = load_val;
      upd   = 1'b1;
    end else if (step) begin
      cnt_d = cnt_q - CW'(1);
      upd   = 1'b1;
    end
  end

  assign zero_evt = upd && (cnt_d == '0);
  assign wrap_evt = step && !clr && !load && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clr && !load && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !clr && !load |=> $stable(cnt_q));
  a_r5_wrap_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clr && !load && (cnt_q == '0) |=> cnt_q == '1);
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/xbc_addr.sv
module xbc_addr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr_q
);
  logic [AW-1:0] addr_d;
  logic          en;

  always_comb begin
    addr_d = addr_q;
    en     = load | step;
    if (load)      addr_d = load_val;
    else if (step) addr_d = addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr_q <= '0;
    else if (en) addr_q <= addr_d;
  end

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> addr_q == $past(addr_q) + AW'(1));
  a_r6_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_q == $past(load_val));
endmodule

// File: rtl/xbc_status.sv
module xbc_status #(
  parameter int unsigned NS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] evt,
  input  logic [NS-1:0] w1c,
  input  logic [NS-1:0] en,
  output logic [NS-1:0] sts_q,
  output logic          irq
);
  logic [NS-1:0] sts_d;

  for (genvar i = 0; i < NS; i++) begin : g_bit
    always_comb sts_d[i] = evt[i] | (sts_q[i] & ~w1c[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[i] <= 1'b0;
      else        sts_q[i] <= sts_d[i];
    end

    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> sts_q[i]);
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      w1c[i] && !evt[i] |=> !sts_q[i]);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      sts_q[i] && !w1c[i] |=> sts_q[i]);
  end

  assign irq = |(sts_q & en);

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q == '0) |-> !irq);
endmodule

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic              cnt_clear,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic [1:0]        sts_w1c,
  input  logic [1:0]        irq_en,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sts_done,
  output logic              sts_wrap,
  output logic              irq
);
  import xbc_pkg::*;

  logic                 step;
  logic                 zero_evt;
  logic                 wrap_evt;
  logic [XBC_NSTAT-1:0] evt;
  logic [XBC_NSTAT-1:0] sts;

  assign step = byte_done & ~cnt_clear & ~cnt_load & ~addr_load;

  xbc_count #(.CW(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .load(cnt_load),
    .load_val(cnt_val), .step(step), .cnt_q(count_o),
    .zero_evt(zero_evt), .wrap_evt(wrap_evt)
  );

  xbc_addr #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(addr_val),
    .step(step), .addr_q(addr_o)
  );

  always_comb begin
    evt          = '0;
    evt[ST_DONE] = zero_evt;
    evt[ST_WRAP] = wrap_evt;
  end

  xbc_status #(.NS(XBC_NSTAT)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(evt), .w1c(sts_w1c), .en(irq_en),
    .sts_q(sts), .irq(irq)
  );

  assign sts_done = sts[ST_DONE];
  assign sts_wrap = sts[ST_WRAP];

  a_r3_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !cnt_clear && !cnt_load && !addr_load
      |=> addr_o == $past(addr_o) + ADDR_W'(1));
  a_r6_strobe_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && addr_load && !cnt_clear && !cnt_load |=> $stable(count_o));
  a_r4_done_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !cnt_clear && !cnt_load && !addr_load && (count_o == CNT_W'(1))
      |=> sts_done);
  a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !cnt_clear && !cnt_load && !addr_load && (count_o == '0)
      |=> sts_wrap);
endmodule

// File: tb/test_xfer_byte_counter.sv
module test_xfer_byte_counter;
  logic        clk;
  logic        rst_n;
  logic        byte_done, cnt_clear, cnt_load, addr_load;
  logic [23:0] cnt_val;
  logic [31:0] addr_val;
  logic [1:0]  sts_w1c, irq_en;
  logic [23:0] count_o;
  logic [31:0] addr_o;
  logic        sts_done, sts_wrap, irq;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  logic [23:0] m_cnt;
  logic [31:0] m_addr;
  logic        m_done, m_wrap;

  xfer_byte_counter i_xfer_byte_counter (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .cnt_clear(cnt_clear),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .addr_load(addr_load),
    .addr_val(addr_val), .sts_w1c(sts_w1c), .irq_en(irq_en),
    .count_o(count_o), .addr_o(addr_o), .sts_done(sts_done),
    .sts_wrap(sts_wrap), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq(input logic [1:0] en);
    return (m_done & en[0]) | (m_wrap & en[1]);
  endfunction

  // Starts at a falling edge; drives, updates the model, samples after the rising edge.
  task automatic cyc(input logic bd, input logic cl, input logic ld, input logic al,
                     input logic [23:0] lv, input logic [31:0] av,
                     input logic [1:0] w, input logic [1:0] en, input string ctx);
    logic        stp, upd, de, we;
    logic [23:0] nc;
    byte_done = bd; cnt_clear = cl; cnt_load = ld; addr_load = al;
    cnt_val = lv; addr_val = av; sts_w1c = w; irq_en = en;
    stp = bd && !cl && !ld && !al;
    we  = stp && (m_cnt == 24'd0);
    upd = cl || ld || stp;
    nc  = cl ? 24'd0 : ld ? lv : stp ? m_cnt - 24'd1 : m_cnt;
    de  = upd && (nc == 24'd0);
    m_cnt  = nc;
    m_addr = al ? av : stp ? m_addr + 32'd1 : m_addr;
    m_done = de | (m_done & ~w[0]);
    m_wrap = we | (m_wrap & ~w[1]);
    @(posedge clk); #2;
    check({"R2 count ", ctx}, {8'd0, count_o}, {8'd0, m_cnt});
    check({"R3 addr ", ctx}, addr_o, m_addr);
    check({"R4 done ", ctx}, {31'd0, sts_done}, {31'd0, m_done});
    check({"R5 wrap ", ctx}, {31'd0, sts_wrap}, {31'd0, m_wrap});
    check({"R8 irq ", ctx}, {31'd0, irq}, {31'd0, exp_irq(en)});
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; byte_done = 0; cnt_clear = 0; cnt_load = 0; addr_load = 0;
    cnt_val = '0; addr_val = '0; sts_w1c = '0; irq_en = 2'b11;
    m_cnt = '0; m_addr = '0; m_done = 0; m_wrap = 0;
    @(posedge clk); #2;
    // R1 reset state
    check("R1 count", {8'd0, count_o}, 32'd0);
    check("R1 addr", addr_o, 32'd0);
    check("R1 done", {31'd0, sts_done}, 32'd0);
    check("R1 wrap", {31'd0, sts_wrap}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    cyc(0,0,1,1, 24'd2, 32'h1000_0000, 2'b00, 2'b00, "R6 load both");
    cyc(1,0,0,0, 0, 0, 2'b00, 2'b00, "R2 dec");
    cyc(1,0,0,0, 0, 0, 2'b00, 2'b01, "R4 reach zero");
    cyc(0,0,0,0, 0, 0, 2'b00, 2'b01, "R9 hold done");
    cyc(1,0,0,0, 0, 0, 2'b00, 2'b10, "R5 wrap");
    cyc(0,0,0,0, 0, 0, 2'b01, 2'b10, "R7 clear done only");
    cyc(0,0,0,0, 0, 0, 2'b00, 2'b11, "R9 wrap sticky");
    cyc(1,0,1,0, 24'd5, 0, 2'b00, 2'b11, "R6 load beats strobe");
    cyc(1,0,0,1, 0, 32'hFFFF_FFFF, 2'b00, 2'b11, "R6 addr load drops strobe");
    cyc(1,0,0,0, 0, 0, 2'b00, 2'b11, "R3 addr wraps");
    cyc(1,1,1,0, 24'd9, 0, 2'b00, 2'b11, "R6 clear beats load");
    cyc(0,0,1,0, 24'd1, 0, 2'b11, 2'b11, "R7 clear both");
    cyc(1,0,0,0, 0, 0, 2'b01, 2'b11, "R7 event beats clear");
    cyc(0,0,0,0, 0, 0, 2'b00, 2'b00, "R8 masked");
    cyc(0,0,0,0, 0, 0, 2'b10, 2'b01, "R7 zero bit keeps");

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic bd, cl, ld, al;
      logic [1:0] w, en;
      bd = ($urandom % 10) < 7;
      cl = ($urandom % 40) == 0;
      ld = ($urandom % 15) == 0;
      al = ($urandom % 20) == 0;
      w  = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      en = 2'($urandom);
      cyc(bd, cl, ld, al, 24'($urandom % 6), $urandom, w, en, "random");
    end

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule